// File: doc/BRIEF.md
# Instruction Prefix Scanner for 64-bit Mode Register Extension

This block watches an instruction byte stream, one byte per clock, and picks out the register-extension prefix that 64-bit code may place in front of an opcode. Each byte arrives with a valid strobe. A start flag marks the first byte of an instruction and an end flag marks the last one. In 64-bit mode a byte from 0x40 to 0x4F inside the prefix run is taken as an extension prefix. Its low nibble yields four one-bit fields: the operand-width bit and three register-index extension bits.

The prefix only counts when it is the last prefix before the first non-prefix byte, which is either the opcode or the 0x0F escape. A later conventional prefix cancels it, and a later extension prefix replaces it. The scanner also enforces the 15-byte instruction limit. It flags an instruction that ends before any opcode was seen. When the mode input is low, no extension prefix is recognised at all.

One cycle after the end byte, a done pulse presents the result for the instruction. The result is the four fields, a present flag, the zero-based position of the opcode byte, and the two fault flags. The outputs then hold until the next instruction ends.

Top module: `rex_scan`

## Requirements
- R1: In 64-bit mode (long_mode=1), a byte 0x40..0x4F in the prefix run is an extension prefix. When it is in force, out_hit=1 and out_w/out_r/out_x/out_b carry bit 3/2/1/0 of that byte.
- R2: The prefix run ends at the first byte that is neither an extension nor a conventional prefix; the 0x0F escape is such a byte. out_opc_at reports that byte's zero-based index.
- R3: The conventional prefixes are 0x26, 0x2E, 0x36, 0x3E, 0x64, 0x65, 0x66, 0x67, 0xF0, 0xF2 and 0xF3. One of them after an extension prefix cancels it, so out_hit=0 unless another extension prefix follows.
- R4: When several extension prefixes appear in one prefix run, only the last one supplies the fields.
- R5: Bytes after the opcode, including 0x40..0x4F, leave the reported fields unchanged.
- R6: With long_mode=0, a byte 0x40..0x4F is an opcode and out_hit stays 0.
- R7: An instruction of 16 or more bytes sets out_len_fault. An instruction of exactly 15 bytes does not.
- R8: An instruction that ends inside its prefix run sets out_no_opc, with out_hit=0, all fields 0 and out_opc_at=0.
- R9: out_done is high for exactly the one cycle after the clock edge that accepts an end byte. The result outputs hold their values until the next end byte.
- R10: Valid bytes that arrive after an end byte and before the next start byte are ignored and produce no out_done.
- R11: When out_hit=0, all four fields are 0, so the operand width stays at the 32-bit default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| long_mode | input | 1 | 1 when executing in 64-bit mode |
| in_valid | input | 1 | Byte strobe |
| in_byte | input | 8 | Instruction byte |
| in_sof | input | 1 | First byte of an instruction |
| in_eof | input | 1 | Last byte of an instruction |
| out_done | output | 1 | One-cycle result strobe |
| out_hit | output | 1 | Extension prefix in force |
| out_w | output | 1 | Operand-width bit (64-bit operands) |
| out_r | output | 1 | Register-field extension bit |
| out_x | output | 1 | Index-field extension bit |
| out_b | output | 1 | Base-field extension bit |
| out_opc_at | output | IDX_W (5) | Zero-based index of the opcode byte, saturating at 16 |
| out_len_fault | output | 1 | Instruction longer than MAX_LEN bytes |
| out_no_opc | output | 1 | Instruction ended without an opcode |

## Verification
A stale pending-prefix flag or field latch shows up in the very next instruction's done cycle. It appears as out_hit or a field bit left set after a conventional prefix, or after a fresh start byte. A byte counter that drifts or fails to saturate shows up at the done of the first instruction of 15 or 16 bytes, as a wrong length fault, or as a wrong opcode index on any instruction with prefixes. A broken active/idle flag shows up one cycle after a stray byte as an unexpected done pulse.

// File: rtl/rex_scan.sv
module rex_scan #(
  parameter int MAX_LEN = 15
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           long_mode,
  input  logic                           in_valid,
  input  logic [7:0]                     in_byte,
  input  logic                           in_sof,
  input  logic                           in_eof,
  output logic                           out_done,
  output logic                           out_hit,
  output logic                           out_w,
  output logic                           out_r,
  output logic                           out_x,
  output logic                           out_b,
  output logic [$clog2(MAX_LEN+2)-1:0]   out_opc_at,
  output logic                           out_len_fault,
  output logic                           out_no_opc
);
  localparam int IDX_W = $clog2(MAX_LEN + 2);
  localparam logic [IDX_W-1:0] SAT = IDX_W'(MAX_LEN + 1);
  localparam logic [IDX_W-1:0] LIM = IDX_W'(MAX_LEN);

  logic             active, in_pfx, pend, found, hit_q;
  logic [3:0]       hold, fld_q;
  logic [IDX_W-1:0] cnt, pos;

  logic             take, pfx_run, is_rex, is_leg, is_opc;
  logic             pend_c, found_c, hit_c;
  logic [3:0]       hold_c, fld_c;
  logic [IDX_W-1:0] idx, pos_c;

  assign take    = in_valid && (in_sof || active);
  assign idx     = in_sof ? '0 : cnt;
  assign pfx_run = in_sof ? 1'b1 : in_pfx;
  assign pend_c  = in_sof ? 1'b0 : pend;
  assign hold_c  = in_sof ? 4'h0 : hold;
  assign found_c = in_sof ? 1'b0 : found;
  assign hit_c   = in_sof ? 1'b0 : hit_q;
  assign fld_c   = in_sof ? 4'h0 : fld_q;
  assign pos_c   = in_sof ? '0 : pos;

  assign is_rex = long_mode && (in_byte[7:4] == 4'h4);

  always_comb begin
    case (in_byte)
      8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65,
      8'h66, 8'h67, 8'hF0, 8'hF2, 8'hF3: is_leg = 1'b1;
      default:                           is_leg = 1'b0;
    endcase
  end

  assign is_opc = pfx_run && !is_rex && !is_leg;

  logic             n_pend, n_found, n_hit;
  logic [3:0]       n_hold, n_fld;
  logic [IDX_W-1:0] n_pos;

  always_comb begin
    n_pend  = pend_c;
    n_hold  = hold_c;
    if (pfx_run && is_rex) begin
      n_pend = 1'b1;
      n_hold = in_byte[3:0];
    end else if (pfx_run && is_leg) begin
      n_pend = 1'b0;
      n_hold = 4'h0;
    end
    n_found = found_c || is_opc;
    n_pos   = is_opc ? idx : pos_c;
    n_hit   = is_opc ? pend_c : hit_c;
    n_fld   = is_opc ? hold_c : fld_c;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      in_pfx <= 1'b0;
      pend   <= 1'b0;
      hold   <= 4'h0;
      found  <= 1'b0;
      hit_q  <= 1'b0;
      fld_q  <= 4'h0;
      cnt    <= '0;
      pos    <= '0;
    end else if (take) begin
      active <= !in_eof;
      in_pfx <= pfx_run && !is_opc;
      pend   <= n_pend;
      hold   <= n_hold;
      found  <= n_found;
      hit_q  <= n_hit;
      fld_q  <= n_fld;
      pos    <= n_pos;
      cnt    <= (idx == SAT) ? idx : idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_done      <= 1'b0;
      out_hit       <= 1'b0;
      {out_w, out_r, out_x, out_b} <= 4'h0;
      out_opc_at    <= '0;
      out_len_fault <= 1'b0;
      out_no_opc    <= 1'b0;
    end else begin
      out_done <= take && in_eof;
      if (take && in_eof) begin
        out_hit       <= n_hit;
        {out_w, out_r, out_x, out_b} <= n_fld;
        out_opc_at    <= n_pos;
        out_len_fault <= (idx >= LIM);
        out_no_opc    <= !n_found;
      end
    end
  end

  assert_fields_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done && !out_hit) |-> ({out_w, out_r, out_x, out_b} == 4'h0));

  assert_no_opc_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done && out_no_opc) |-> (!out_hit && out_opc_at == '0));

  assert_done_after_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> $past(in_valid && in_eof));

  assert_prefix_before_opc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done && out_hit) |-> (out_opc_at != '0));

  assert_legacy_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && in_eof && !long_mode) |=> !out_hit);
endmodule

// File: tb/rex_scan_tb.sv
module rex_scan_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       long_mode = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       in_sof = 1'b0;
  logic       in_eof = 1'b0;
  logic       out_done, out_hit, out_w, out_r, out_x, out_b;
  logic [4:0] out_opc_at;
  logic       out_len_fault, out_no_opc;

  int vec = 0;
  int bad = 0;
  bit finished = 0;
  logic [7:0] ibuf [0:31];

  always #4 clk = ~clk;

  rex_scan u_dut (
    .clk(clk), .rst_n(rst_n), .long_mode(long_mode),
    .in_valid(in_valid), .in_byte(in_byte), .in_sof(in_sof), .in_eof(in_eof),
    .out_done(out_done), .out_hit(out_hit), .out_w(out_w), .out_r(out_r),
    .out_x(out_x), .out_b(out_b), .out_opc_at(out_opc_at),
    .out_len_fault(out_len_fault), .out_no_opc(out_no_opc)
  );

  function automatic bit legacy(input logic [7:0] b);
    return b inside {8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65,
                     8'h66, 8'h67, 8'hF0, 8'hF2, 8'hF3};
  endfunction

  // {done, hit, w, r, x, b, pos[4:0], len_fault, no_opc}
  function automatic logic [12:0] model(input int n, input bit lm);
    bit pend = 0, found = 0, hit = 0;
    logic [3:0] hold = 0, fld = 0;
    logic [4:0] pos = 0;
    for (int i = 0; i < n; i++) begin
      if (!found) begin
        if (lm && ibuf[i][7:4] == 4'h4) begin
          pend = 1; hold = ibuf[i][3:0];
        end else if (legacy(ibuf[i])) begin
          pend = 0; hold = 0;
        end else begin
          found = 1; pos = (i > 16) ? 5'd16 : 5'(i); hit = pend; fld = hold;
        end
      end
    end
    return {1'b1, hit, fld, pos, (n >= 16), !found};
  endfunction

  task automatic check(input string tag, input logic [12:0] exp);
    logic [12:0] act;
    act = {out_done, out_hit, out_w, out_r, out_x, out_b, out_opc_at,
           out_len_fault, out_no_opc};
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic run(input string tag, input int n, input bit lm);
    logic [12:0] exp;
    exp = model(n, lm);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      long_mode = lm;
      in_valid = 1; in_byte = ibuf[i];
      in_sof = (i == 0); in_eof = (i == n - 1);
    end
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0;
    check(tag, exp);
  endtask

  task automatic load3(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    ibuf[0] = a; ibuf[1] = b; ibuf[2] = c;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      bad++; vec++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9 reset state", 13'b0);

    load3(8'h48, 8'h8B, 8'h00);
    run("R1 width prefix", 2, 1);
    @(negedge clk);
    check("R9 single pulse and hold", 13'b0_1_1000_00001_0_0);

    load3(8'h45, 8'h0F, 8'hAF);
    run("R2 prefix before escape", 3, 1);

    load3(8'h48, 8'h66, 8'h8B);
    run("R3 legacy cancels prefix", 3, 1);

    load3(8'h66, 8'h49, 8'h89);
    run("R1 legacy then prefix", 3, 1);

    load3(8'h42, 8'h4C, 8'h8B);
    run("R4 last prefix wins", 3, 1);

    load3(8'h8B, 8'h4F, 8'h41);
    run("R5 late bytes ignored", 3, 1);

    load3(8'h48, 8'h8B, 8'h00);
    run("R6 no prefix outside 64-bit mode", 2, 0);

    ibuf[0] = 8'h44;
    run("R6 single byte opcode in legacy mode", 1, 0);

    load3(8'h66, 8'h41, 8'h00);
    run("R8 prefixes only", 2, 1);

    load3(8'h8B, 8'hC0, 8'h00);
    run("R11 no prefix default width", 2, 1);

    for (int i = 0; i < 32; i++) ibuf[i] = (i < 3) ? 8'hF3 : 8'h90;
    ibuf[3] = 8'h4A; ibuf[4] = 8'h0F;
    run("R7 exactly fifteen bytes", 15, 1);
    run("R7 sixteen bytes", 16, 1);
    for (int i = 0; i < 18; i++) ibuf[i] = 8'h66;
    ibuf[17] = 8'h48;
    run("R7 R8 eighteen prefix bytes", 18, 1);

    @(negedge clk);
    in_valid = 1; in_byte = 8'h48; in_sof = 0; in_eof = 1;
    @(negedge clk);
    in_valid = 0; in_eof = 0;
    vec++;
    if (out_done !== 1'b0) begin
      bad++;
      $display("FAIL R10 stray byte actual=%b expected=0", out_done);
    end

    for (int k = 0; k < 400; k++) begin
      int n;
      bit lm;
      n = 1 + int'($urandom_range(17));
      lm = ($urandom_range(3) != 0);
      for (int i = 0; i < n; i++) begin
        int c;
        c = int'($urandom_range(9));
        if (c < 3)      ibuf[i] = {4'h4, 4'($urandom_range(15))};
        else if (c < 6) ibuf[i] = (c == 3) ? 8'h66 : ((c == 4) ? 8'hF0 : 8'h2E);
        else if (c == 6) ibuf[i] = 8'h0F;
        else            ibuf[i] = 8'($urandom_range(255));
      end
      run("R1 R2 R3 R4 R5 random", n, lm);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule